// File: doc/BRIEF.md
# Auto-Incrementing Work-RAM Data Port

This block gives a processor byte-wide access to a 128 KiB work memory through a single data register. A 17-bit pointer selects the byte. Software loads the pointer with byte writes to three pointer registers. It then moves data by reading or writing the data register repeatedly. Each data access reaches the memory byte at the pointer, and the pointer then steps forward by one. A long block copy therefore needs only one register address.

On the processor side the block has a small register bus: an offset, write data, read data, and read and write strobes. On the memory side it has a byte bus: address, write data, read data, and read and write enables. The pointer is placed inside a fixed base region, so the memory address always falls in the same 128 KiB window.

The data path is combinational within the access cycle. The memory read data comes back on the same cycle the strobe is high. The pointer register updates at the clock edge that ends the access.

Top module: `wram_window_port`

## Requirements
- R1: After synchronous reset the pointer is zero, so the first data access reaches memory address 0x7E0000.
- R2: A write to offset 1 loads pointer bits 7:0 from the write data and leaves pointer bits 16:8 unchanged.
- R3: A write to offset 2 loads pointer bits 15:8 from the write data and leaves pointer bits 16 and 7:0 unchanged.
- R4: A write to offset 3 loads pointer bit 16 from write data bit 0. Write data bits 7:1 are ignored, and pointer bits 15:0 are unchanged.
- R5: A read of offset 0 raises the memory read enable for that cycle with address 0x7E0000 plus the pointer, and returns the memory byte on the processor read data.
- R6: A write to offset 0 raises the memory write enable for that cycle, with the same address rule as R5 and the processor write data on the memory write data.
- R7: Every data-register access, read or write, advances the pointer by exactly one at the end of that cycle. Cycles with no data access leave the pointer unchanged.
- R8: Advancing the pointer from 0x1FFFF yields 0x00000.
- R9: A read of offset 1, 2 or 3, or a cycle with no read strobe, returns the bus-hold input on the processor read data. Such a read raises no memory enable and does not change the pointer.
- R10: When the read and write strobes are both high at offset 0, only the write takes place. The memory read and write enables are never high together, and the pointer advances once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 2 | Register offset: 0 data, 1 pointer low, 2 pointer middle, 3 pointer top |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| open_bus | input | 8 | Bus-hold value returned for reads that do not reach memory |
| cpu_rdata | output | 8 | Processor read data |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |

## Verification
Each pointer byte is swept through all 256 values while the other bytes hold distinctive contents. A design that loads the wrong lane or clears its neighbours shows up as a wrong memory address on the next data access. The wrap from 0x1FFFF is exercised, because a pointer that carries into the base bits or saturates would leave the 128 KiB window or stall. Reads of the pointer offsets are checked to return the bus-hold byte with no memory enable and no pointer movement; a decoder that leaked data reads onto those offsets would fail here. Simultaneous strobes are checked to yield exactly one write and one increment, which catches a design that double-steps or drives both memory enables.

// File: rtl/wram_port_pkg.sv
package wram_port_pkg;

    // Register offsets within the block's window; the order of the
    // three pointer bytes is fixed by software that loads them.
    typedef enum logic [1:0] {
        SEL_DATA    = 2'd0,
        SEL_PTR_LO  = 2'd1,
        SEL_PTR_MID = 2'd2,
        SEL_PTR_HI  = 2'd3
    } reg_sel_e;

    // One decoded operation per cycle; at most one field is set.
    typedef struct packed {
        logic data_rd;
        logic data_wr;
        logic ld_lo;
        logic ld_mid;
        logic ld_hi;
    } port_op_t;

    localparam int BYTE_W = 8;

    function automatic logic is_data_access(input port_op_t op);
        return op.data_rd | op.data_wr;
    endfunction

endpackage

// File: rtl/wram_port_decode.sv
module wram_port_decode
    import wram_port_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic [OFF_W-1:0] cpu_addr,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    output port_op_t         op
);
    reg_sel_e sel;
    logic     hit;

    generate
        if (OFF_W > 2) begin : g_wide
            assign hit = (cpu_addr[OFF_W-1:2] == '0);
        end else begin : g_narrow
            assign hit = 1'b1;
        end
    endgenerate

    assign sel = reg_sel_e'(cpu_addr[1:0]);

    always_comb begin
        op = '0;
        if (hit) begin
            unique case (sel)
                SEL_DATA: begin
                    op.data_wr = cpu_wr;
                    op.data_rd = cpu_rd & ~cpu_wr;
                end
                SEL_PTR_LO:  op.ld_lo  = cpu_wr;
                SEL_PTR_MID: op.ld_mid = cpu_wr;
                SEL_PTR_HI:  op.ld_hi  = cpu_wr;
                default: op = '0;
            endcase
        end
    end
endmodule

// File: rtl/wram_ptr_reg.sv
module wram_ptr_reg
    import wram_port_pkg::*;
#(
    parameter int PTR_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  port_op_t         op,
    input  logic [7:0]       wdata,
    output logic [PTR_W-1:0] ptr_q
);
    localparam int HI_W = PTR_W - 16;

    logic [PTR_W-1:0] ptr_d;
    logic [PTR_W-1:0] ptr_inc;

    assign ptr_inc = ptr_q + {{(PTR_W-1){1'b0}}, 1'b1};

    always_comb begin
        ptr_d = ptr_q;
        if (is_data_access(op)) begin
            ptr_d = ptr_inc;
        end else if (op.ld_lo) begin
            ptr_d[7:0] = wdata;
        end else if (op.ld_mid) begin
            ptr_d[15:8] = wdata;
        end else if (op.ld_hi) begin
            ptr_d[PTR_W-1:16] = wdata[HI_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end
endmodule

// File: rtl/wram_port_rmux.sv
module wram_port_rmux
    import wram_port_pkg::*;
(
    input  port_op_t   op,
    input  logic [7:0] mem_rdata,
    input  logic [7:0] open_bus,
    output logic [7:0] cpu_rdata
);
    always_comb begin
        cpu_rdata = op.data_rd ? mem_rdata : open_bus;
    end
endmodule

// File: rtl/wram_window_port.sv
module wram_window_port
    import wram_port_pkg::*;
#(
    parameter int                 OFF_W     = 2,
    parameter int                 PTR_W     = 17,
    parameter int                 MEM_AW    = 24,
    parameter logic [MEM_AW-1:0]  BASE_ADDR = 24'h7E0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFF_W-1:0]  cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [7:0]        open_bus,
    output logic [7:0]        cpu_rdata,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr
);
    localparam int PAD_W = MEM_AW - PTR_W;

    port_op_t         op;
    logic [PTR_W-1:0] ptr_q;

    wram_port_decode #(.OFF_W(OFF_W)) u_decode (
        .cpu_addr (cpu_addr),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .op       (op)
    );

    wram_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .wdata (cpu_wdata),
        .ptr_q (ptr_q)
    );

    wram_port_rmux u_rmux (
        .op        (op),
        .mem_rdata (mem_rdata),
        .open_bus  (open_bus),
        .cpu_rdata (cpu_rdata)
    );

    assign mem_addr  = BASE_ADDR | {{PAD_W{1'b0}}, ptr_q};
    assign mem_wdata = cpu_wdata;
    assign mem_rd    = op.data_rd;
    assign mem_wr    = op.data_wr;
endmodule

// File: rtl/wram_window_port_chk.sv
module wram_window_port_chk #(
    parameter int OFF_W  = 2,
    parameter int PTR_W  = 17,
    parameter int MEM_AW = 24
) (
    input logic              clk,
    input logic              rst,
    input logic [OFF_W-1:0]  cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [7:0]        open_bus,
    input logic [7:0]        cpu_rdata,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [7:0]        mem_rdata,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [PTR_W-1:0]  ptr_q
);
    logic [PTR_W-1:0] ptr_plus;
    assign ptr_plus = ptr_q + {{(PTR_W-1){1'b0}}, 1'b1};

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_post_inc_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |=> ptr_q == $past(ptr_plus));

    assert_rdata_R5: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> cpu_rdata == mem_rdata);

    assert_addr_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> mem_addr[PTR_W-1:0] == ptr_q);

    assert_lo_load_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == OFF_W'(1)) |=>
        (ptr_q[7:0] == $past(cpu_wdata)) && (ptr_q[PTR_W-1:8] == $past(ptr_q[PTR_W-1:8])));

    assert_hi_load_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == OFF_W'(3)) |=> ptr_q[15:0] == $past(ptr_q[15:0]));

    assert_bus_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !cpu_wr && cpu_addr != '0) |-> (!mem_rd && cpu_rdata == open_bus));

    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!cpu_wr && !mem_rd) |=> $stable(ptr_q));
endmodule

bind wram_window_port wram_window_port_chk #(
    .OFF_W (OFF_W),
    .PTR_W (PTR_W),
    .MEM_AW(MEM_AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .open_bus  (open_bus),
    .cpu_rdata (cpu_rdata),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .ptr_q     (ptr_q)
);

// File: tb/test_wram_window_port.sv
`timescale 1ns/1ps
module test_wram_window_port;
    localparam logic [23:0] BASE = 24'h7E0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  open_bus = 8'hC3;
    logic [7:0]  cpu_rdata;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_rd;
    logic        mem_wr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [16:0] mptr;

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h3C;
    endfunction

    // Memory model: read data is a computed pattern of the address.
    assign mem_rdata = pat(mem_addr[16:0]);

    wram_window_port i_wram_window_port (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .open_bus(open_bus),
        .cpu_rdata(cpu_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] off, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = off; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(posedge clk); #1;
        cpu_wr = 1'b0;
        case (off)
            2'd1: mptr[7:0]  = d;
            2'd2: mptr[15:8] = d;
            2'd3: mptr[16]   = d[0];
            default: mptr = mptr + 17'd1;
        endcase
    endtask

    task automatic set_ptr(input logic [16:0] p);
        wr_reg(2'd1, p[7:0]);
        wr_reg(2'd2, p[15:8]);
        wr_reg(2'd3, {7'h55, p[16]});
    endtask

    task automatic rd_data(input string req);
        @(negedge clk);
        cpu_addr = 2'd0; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
        check(mem_rd === 1'b1 && mem_wr === 1'b0, req, {mem_rd, mem_wr}, 2'b10);
        check(mem_addr === (BASE | {7'd0, mptr}), req, mem_addr, BASE | {7'd0, mptr});
        check(cpu_rdata === pat(mptr), req, cpu_rdata, pat(mptr));
        @(posedge clk); #1;
        cpu_rd = 1'b0;
        mptr = mptr + 17'd1;
    endtask

    task automatic wr_data(input logic [7:0] d, input string req);
        @(negedge clk);
        cpu_addr = 2'd0; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        #1;
        check(mem_wr === 1'b1 && mem_rd === 1'b0, req, {mem_rd, mem_wr}, 2'b01);
        check(mem_addr === (BASE | {7'd0, mptr}), req, mem_addr, BASE | {7'd0, mptr});
        check(mem_wdata === d, req, mem_wdata, d);
        @(posedge clk); #1;
        cpu_wr = 1'b0;
        mptr = mptr + 17'd1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        mptr = '0;
        repeat (3) @(posedge clk);
        #1;
        check(mem_rd === 1'b0 && mem_wr === 1'b0, "R1", {mem_rd, mem_wr}, 2'b00);
        rst = 1'b0;
        // R1: first access after reset at pointer zero
        rd_data("R1");
        wr_data(8'h11, "R6");

        // R7: consecutive reads and writes each advance once
        set_ptr(17'h12345);
        for (int i = 0; i < 8; i++) begin
            if (i % 2 == 0) rd_data("R7");
            else            wr_data(8'(i), "R7");
        end
        // idle cycles: pointer must hold (R7)
        repeat (5) @(posedge clk);
        rd_data("R7");

        // R2: low byte sweep, other bits preserved
        set_ptr(17'h15A00);
        for (int v = 0; v < 256; v++) begin
            wr_reg(2'd1, 8'(v));
            rd_data("R2");
        end

        // R3: middle byte sweep
        set_ptr(17'h000A7);
        for (int v = 0; v < 256; v++) begin
            wr_reg(2'd2, 8'(v));
            wr_reg(2'd1, 8'hA7);
            rd_data("R3");
        end

        // R4: only bit 0 of the top register matters
        set_ptr(17'h0BEEF);
        wr_reg(2'd3, 8'hFE); rd_data("R4");
        wr_reg(2'd1, 8'hEF);
        wr_reg(2'd3, 8'h01); rd_data("R4");
        wr_reg(2'd1, 8'hEF);
        wr_reg(2'd3, 8'hFF); rd_data("R4");
        wr_reg(2'd3, 8'h00); wr_data(8'h77, "R4");

        // R8: wrap at the top of the window
        set_ptr(17'h1FFFF);
        rd_data("R8");
        check(mptr === 17'h00000, "R8", mptr, 17'h0);
        wr_data(8'h99, "R8");
        set_ptr(17'h1FFFF);
        wr_data(8'h5A, "R8");
        rd_data("R8");

        // R9: pointer-register reads return bus-hold, no memory access
        set_ptr(17'h0C0DE);
        for (int off = 1; off < 4; off++) begin
            @(negedge clk);
            open_bus = 8'(8'h90 + off);
            cpu_addr = 2'(off); cpu_rd = 1'b1; cpu_wr = 1'b0;
            #1;
            check(cpu_rdata === open_bus, "R9", cpu_rdata, open_bus);
            check(mem_rd === 1'b0 && mem_wr === 1'b0, "R9", {mem_rd, mem_wr}, 2'b00);
            @(posedge clk); #1;
            cpu_rd = 1'b0;
        end
        #1;
        check(cpu_rdata === open_bus, "R9", cpu_rdata, open_bus);
        rd_data("R9");

        // R10: both strobes at the data offset -> one write, one step
        @(negedge clk);
        cpu_addr = 2'd0; cpu_rd = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'h3D;
        #1;
        check(mem_wr === 1'b1 && mem_rd === 1'b0, "R10", {mem_rd, mem_wr}, 2'b01);
        check(mem_addr === (BASE | {7'd0, mptr}), "R10", mem_addr, BASE | {7'd0, mptr});
        @(posedge clk); #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        mptr = mptr + 17'd1;
        rd_data("R10");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule